// File: doc/BRIEF.md
# Serial Command/Data Byte Deserializer

This block receives bytes over a write-only serial link made of an active-low chip select, a serial clock and a data line. It rebuilds each byte in the system clock domain and hands it on as a one-cycle parallel write. Each write carries a flag that says whether the byte is a command or display data. A downstream register file or display RAM port consumes these writes. A separate pulse tells the RAM column counter to advance by one for every display data byte.

The block has two link modes, picked by a static mode input. In four-wire mode a register-select input tags each byte. In three-wire mode there is no tag pin, so the tag is carried in the byte stream itself. Every byte is a command unless a data-direction command (0xE8) arrives. The byte after it is a length value L, and the next L+1 bytes are display data. After those bytes the block falls back to command mode by itself.

The serial clock, data, select and chip select inputs are synchronised into the system clock. The system clock must run at least four times faster than the serial clock.

Top module: `serial_cmd_deser`

## Requirements
- R1: The data line is sampled on each rising serial clock edge while chip select is low. Bits arrive most significant first. The byte is released after the eighth such edge, and `byte_o` holds the eight bits in arrival order with bit 7 first.
- R2: Each received byte produces exactly one `byte_vld_o` pulse one system clock wide. `byte_o` and `is_data_o` are valid in that cycle and keep their values until the next pulse.
- R3: While chip select is high, the shift register and bit counter are held cleared. A byte cut short by a chip-select release is dropped without a strobe. The next transfer starts again from bit 7.
- R4: In four-wire mode (`four_wire_i` = 1), `is_data_o` equals the level of `rs_i` at the eighth serial clock edge: 1 means display data and 0 means command.
- R5: In three-wire mode (`four_wire_i` = 0), every byte outside a counted data run is tagged as a command (`is_data_o` = 0), and `rs_i` has no effect.
- R6: In three-wire mode, the command byte 0xE8 makes the following byte a length value. Both bytes are delivered as commands.
- R7: In three-wire mode, a length value L (0 to 127) makes exactly the next L+1 bytes display data (`is_data_o` = 1). The byte after them is a command again.
- R8: In three-wire mode, a length value above 127 is treated as 127, so 128 data bytes follow.
- R9: In three-wire mode, a chip-select release returns the tagging sequence to command mode. This applies while a length byte is expected and during a data run.
- R10: `col_inc_o` pulses in the same cycle as `byte_vld_o` for every display data byte, and never for a command byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| four_wire_i | input | 1 | 1: tag from `rs_i`; 0: in-band tagging |
| cs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock, data sampled on rising edge |
| sdi_i | input | 1 | Serial data, MSB first |
| rs_i | input | 1 | Register select in four-wire mode, 1 = display data |
| byte_vld_o | output | 1 | One-cycle strobe for a received byte |
| byte_o | output | 8 | Received byte |
| is_data_o | output | 1 | 1 = display data, 0 = command |
| col_inc_o | output | 1 | Column address increment pulse |

## Verification
The hardest case to reach is a chip-select release in the middle of a three-wire data run or between the 0xE8 command and its length byte. The tagging state must then fall back to command mode even though the counted run is unfinished. Directed sequences open a counted run, stop after part of it or straight after 0xE8, release chip select, and then send a byte whose expected tag is a command. Random three-wire streams with embedded 0xE8 bytes and random lengths are compared against a bench model of the tagging sequence. Length values above 127 are forced to hit the saturated 128-byte run.

// File: rtl/deser_pkg.sv
package deser_pkg;
  typedef enum logic [1:0] {
    ST_CMD  = 2'd0,
    ST_LEN  = 2'd1,
    ST_DATA = 2'd2
  } seq_st_e;
endpackage

// File: rtl/deser_sync.sv
module deser_sync #(
  parameter int          W      = 4,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/deser_shift.sv
module deser_shift #(
  parameter int DW = 8,
  localparam int CNT_W = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_n_s_i,
  input  logic          sclk_s_i,
  input  logic          sdi_s_i,
  input  logic          rs_s_i,
  output logic          vld_o,
  output logic [DW-1:0] byte_o,
  output logic          rs_o
);
  logic             sclk_q;
  logic [DW-2:0]    sr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;
  logic             last_bit;

  assign rise     = sclk_s_i & ~sclk_q & ~cs_n_s_i;
  assign last_bit = (cnt_q == CNT_W'(DW - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (cs_n_s_i) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (rise) begin
      sr_q  <= {sr_q[DW-3:0], sdi_s_i};
      cnt_q <= last_bit ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      byte_o <= '0;
      rs_o   <= 1'b0;
    end else begin
      vld_o <= rise & last_bit;
      if (rise && last_bit) begin
        byte_o <= {sr_q, sdi_s_i};
        rs_o   <= rs_s_i;
      end
    end
  end
endmodule

// File: rtl/deser_seq.sv
module deser_seq
  import deser_pkg::*;
#(
  parameter int          DW       = 8,
  parameter int          MAX_LEN  = 127,
  parameter logic [DW-1:0] DDC_CODE = 8'hE8,
  localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          four_wire_i,
  input  logic          abort_i,
  input  logic          vld_i,
  input  logic [DW-1:0] byte_i,
  input  logic          rs_i,
  output logic          vld_o,
  output logic [DW-1:0] byte_o,
  output logic          is_data_o,
  output logic          col_inc_o
);
  seq_st_e          st_q;
  logic [LEN_W-1:0] rem_q;
  logic [LEN_W-1:0] len_sat;

  always_comb begin
    if (byte_i > DW'(MAX_LEN)) len_sat = LEN_W'(MAX_LEN);
    else                       len_sat = byte_i[LEN_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_CMD;
      rem_q     <= '0;
      vld_o     <= 1'b0;
      byte_o    <= '0;
      is_data_o <= 1'b0;
      col_inc_o <= 1'b0;
    end else begin
      vld_o     <= vld_i;
      col_inc_o <= 1'b0;
      if (vld_i) begin
        byte_o <= byte_i;
        if (four_wire_i) begin
          is_data_o <= rs_i;
          col_inc_o <= rs_i;
        end else begin
          case (st_q)
            ST_LEN: begin
              is_data_o <= 1'b0;
              rem_q     <= len_sat;
              st_q      <= ST_DATA;
            end
            ST_DATA: begin
              is_data_o <= 1'b1;
              col_inc_o <= 1'b1;
              if (rem_q == '0) st_q <= ST_CMD;
              else             rem_q <= rem_q - LEN_W'(1);
            end
            default: begin
              is_data_o <= 1'b0;
              if (byte_i == DDC_CODE) st_q <= ST_LEN;
            end
          endcase
        end
      end
      if (abort_i || four_wire_i) begin
        st_q  <= ST_CMD;
        rem_q <= '0;
      end
    end
  end
endmodule

// File: rtl/serial_cmd_deser.sv
module serial_cmd_deser #(
  parameter int          DW       = 8,
  parameter int          SYNC_STG = 2,
  parameter int          MAX_LEN  = 127,
  parameter logic [DW-1:0] DDC_CODE = 8'hE8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          four_wire_i,
  input  logic          cs_ni,
  input  logic          sclk_i,
  input  logic          sdi_i,
  input  logic          rs_i,
  output logic          byte_vld_o,
  output logic [DW-1:0] byte_o,
  output logic          is_data_o,
  output logic          col_inc_o
);
  localparam int NSIG = 4;

  logic [NSIG-1:0] raw, synced;
  logic            sh_vld, sh_rs;
  logic [DW-1:0]   sh_byte;

  assign raw = {cs_ni, sclk_i, sdi_i, rs_i};

  deser_sync #(
    .W(NSIG), .STAGES(SYNC_STG), .RST_VAL(NSIG'(4'b1000))
  ) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(synced)
  );

  deser_shift #(.DW(DW)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_n_s_i (synced[3]),
    .sclk_s_i (synced[2]),
    .sdi_s_i  (synced[1]),
    .rs_s_i   (synced[0]),
    .vld_o    (sh_vld),
    .byte_o   (sh_byte),
    .rs_o     (sh_rs)
  );

  deser_seq #(.DW(DW), .MAX_LEN(MAX_LEN), .DDC_CODE(DDC_CODE)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .four_wire_i (four_wire_i),
    .abort_i     (synced[3]),
    .vld_i       (sh_vld),
    .byte_i      (sh_byte),
    .rs_i        (sh_rs),
    .vld_o       (byte_vld_o),
    .byte_o      (byte_o),
    .is_data_o   (is_data_o),
    .col_inc_o   (col_inc_o)
  );
endmodule

// File: rtl/serial_cmd_deser_chk.sv
module serial_cmd_deser_chk #(
  parameter int          DW       = 8,
  parameter logic [DW-1:0] DDC_CODE = 8'hE8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          four_wire_i,
  input logic          cs_ni,
  input logic          byte_vld_o,
  input logic [DW-1:0] byte_o,
  input logic          is_data_o,
  input logic          col_inc_o
);
  logic [2:0] cs_hi_cnt;
  logic       quiet;
  logic       last_data, last_len, last_ddc;

  assign quiet = (cs_hi_cnt >= 3'd6);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cs_hi_cnt <= 3'd0;
    else if (!cs_ni)              cs_hi_cnt <= 3'd0;
    else if (cs_hi_cnt != 3'd7)   cs_hi_cnt <= cs_hi_cnt + 3'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_data <= 1'b0;
      last_len  <= 1'b0;
      last_ddc  <= 1'b0;
    end else if (quiet || four_wire_i) begin
      last_data <= 1'b0;
      last_len  <= 1'b0;
      last_ddc  <= 1'b0;
    end else if (byte_vld_o) begin
      last_data <= is_data_o;
      last_len  <= !is_data_o && last_ddc;
      last_ddc  <= !is_data_o && (byte_o == DDC_CODE) && !last_ddc;
    end
  end

  assert_strobe_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);

  assert_tag_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld_o |-> $stable(is_data_o));

  assert_cs_idle_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet |-> !byte_vld_o);

  assert_data_entry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!four_wire_i && byte_vld_o && is_data_o) |-> (last_data || last_len));

  assert_col_inc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_inc_o == (byte_vld_o && is_data_o));
endmodule

bind serial_cmd_deser serial_cmd_deser_chk #(.DW(DW), .DDC_CODE(DDC_CODE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .four_wire_i (four_wire_i),
  .cs_ni       (cs_ni),
  .byte_vld_o  (byte_vld_o),
  .byte_o      (byte_o),
  .is_data_o   (is_data_o),
  .col_inc_o   (col_inc_o)
);

// File: tb/serial_cmd_deser_bench.sv
module serial_cmd_deser_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       four_wire_i = 1'b1;
  logic       cs_ni = 1'b1;
  logic       sclk_i = 1'b0;
  logic       sdi_i = 1'b0;
  logic       rs_i = 1'b0;
  logic       byte_vld_o;
  logic [7:0] byte_o;
  logic       is_data_o;
  logic       col_inc_o;

  int checks = 0;
  int fails = 0;

  logic [8:0] got_q[$];
  logic [8:0] exp_q[$];
  int         inc_cnt = 0;
  int         dbl_strobe = 0;
  logic       prev_vld = 1'b0;

  int         m_state = 0;
  int         m_rem = 0;

  always #10 clk_i = ~clk_i;

  serial_cmd_deser u_serial_cmd_deser (
    .clk_i(clk_i), .rst_ni(rst_ni), .four_wire_i(four_wire_i), .cs_ni(cs_ni),
    .sclk_i(sclk_i), .sdi_i(sdi_i), .rs_i(rs_i), .byte_vld_o(byte_vld_o),
    .byte_o(byte_o), .is_data_o(is_data_o), .col_inc_o(col_inc_o)
  );

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (byte_vld_o) got_q.push_back({is_data_o, byte_o});
      if (col_inc_o) inc_cnt++;
      if (byte_vld_o && prev_vld) dbl_strobe++;
      prev_vld = byte_vld_o;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic cs_low();
    cs_ni = 1'b0;
    wait_clk(4);
  endtask

  task automatic cs_high();
    wait_clk(4);
    cs_ni = 1'b1;
    wait_clk(10);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits, input logic rs);
    rs_i = rs;
    for (int i = 7; i > 7 - nbits; i--) begin
      sdi_i  = b[i];
      sclk_i = 1'b0;
      wait_clk(4);
      sclk_i = 1'b1;
      wait_clk(4);
    end
    sclk_i = 1'b0;
  endtask

  task automatic send4(input logic [7:0] b, input logic rs);
    exp_q.push_back({rs, b});
    send_bits(b, 8, rs);
  endtask

  task automatic model3(input logic [7:0] b);
    case (m_state)
      0: begin exp_q.push_back({1'b0, b}); if (b == 8'hE8) m_state = 1; end
      1: begin exp_q.push_back({1'b0, b}); m_rem = (b > 127) ? 127 : int'(b); m_state = 2; end
      default: begin
        exp_q.push_back({1'b1, b});
        if (m_rem == 0) m_state = 0; else m_rem--;
      end
    endcase
  endtask

  task automatic send3(input logic [7:0] b);
    model3(b);
    send_bits(b, 8, 1'($urandom_range(0, 1)));
  endtask

  task automatic cs_high3();
    cs_high();
    m_state = 0;
    m_rem = 0;
  endtask

  task automatic compare_run(input string req);
    int ndata = 0;
    wait_clk(12);
    check(got_q.size() == exp_q.size(), {req, " byte count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size(); i++) begin
      if (exp_q[i][8]) ndata++;
      if (i < got_q.size())
        check(got_q[i] == exp_q[i], {req, " tag+byte"}, int'(got_q[i]), int'(exp_q[i]));
    end
    check(inc_cnt == ndata, "R10 col_inc count", inc_cnt, ndata);
    check(dbl_strobe == 0, "R2 strobe width", dbl_strobe, 0);
    got_q.delete();
    exp_q.delete();
    inc_cnt = 0;
    dbl_strobe = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0755));
    wait_clk(5);
    check(byte_vld_o == 1'b0, "R2 reset strobe", byte_vld_o, 0);
    check(col_inc_o == 1'b0, "R10 reset col_inc", col_inc_o, 0);
    rst_ni = 1'b1;
    wait_clk(5);
    check(byte_vld_o == 1'b0 && is_data_o == 1'b0 && byte_o == 8'h00,
          "R2 post-reset outputs", {byte_vld_o, is_data_o, byte_o}, 0);

    // R1 R4: four-wire, directed bit patterns and random tags
    four_wire_i = 1'b1;
    cs_low();
    send4(8'h80, 1'b1);
    send4(8'h01, 1'b0);
    send4(8'hA5, 1'b1);
    send4(8'hE8, 1'b0);
    for (int i = 0; i < 24; i++) send4(8'($urandom), 1'($urandom_range(0, 1)));
    cs_high();
    compare_run("R1 R4 four-wire");

    // R3: partial byte dropped, next transfer restarts at bit 7
    cs_low();
    send_bits(8'hFF, 7, 1'b1);
    cs_high();
    compare_run("R3 seven-bit abort");
    cs_low();
    send_bits(8'hF0, 4, 1'b0);
    cs_high();
    cs_low();
    send4(8'h3C, 1'b1);
    cs_high();
    compare_run("R3 restart after abort");

    // R5: three-wire default command, rs ignored
    four_wire_i = 1'b0;
    wait_clk(4);
    cs_low();
    for (int i = 0; i < 10; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      if (b == 8'hE8) b = 8'h00;
      send3(b);
    end
    cs_high3();
    compare_run("R5 three-wire commands");

    // R6 R7: length 0 gives one data byte
    cs_low();
    send3(8'hE8); send3(8'h00); send3(8'h55); send3(8'h12);
    cs_high3();
    compare_run("R6 R7 length zero");

    // R7: length 127 gives 128 bytes, then command
    cs_low();
    send3(8'hE8); send3(8'd127);
    for (int i = 0; i < 128; i++) send3(8'($urandom));
    send3(8'hE8);
    cs_high3();
    compare_run("R7 length 127");

    // R8: length above 127 saturates
    cs_low();
    send3(8'hE8); send3(8'hC8);
    for (int i = 0; i < 130; i++) send3(8'($urandom));
    cs_high3();
    compare_run("R8 saturated length");

    // R9: release during data run and between E8 and length
    cs_low();
    send3(8'hE8); send3(8'd5); send3(8'h11); send3(8'h22);
    cs_high3();
    cs_low();
    send3(8'h33); send3(8'h44);
    cs_high3();
    compare_run("R9 abort in data run");
    cs_low();
    send3(8'hE8);
    cs_high3();
    cs_low();
    send3(8'h07); send3(8'h66);
    cs_high3();
    compare_run("R9 abort before length");

    // R7 random streams with embedded data-direction commands
    for (int r = 0; r < 4; r++) begin
      cs_low();
      for (int i = 0; i < 40; i++) begin
        int sel;
        sel = $urandom_range(0, 9);
        if (sel == 0 && m_state == 0) begin
          send3(8'hE8);
          send3(8'($urandom_range(0, 6)));
        end else begin
          send3(8'($urandom));
        end
      end
      cs_high3();
      compare_run("R7 random three-wire");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule